// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Unit

This block collects single-cycle event pulses from five interrupt sources into sticky flag bits. Three sources are external pins and two come from a timer, one for compare-match and one for overflow. For each source it holds an enable bit, and it also honours a global enable input. Whenever at least one enabled flag is pending and the global enable is high, it raises a request to the core and presents the fixed vector address of the winning source.

The core acknowledges with a one-cycle pulse. That pulse clears only the flag whose vector is on the output at that moment. Software can also clear an external flag by writing a one to its bit. Software reaches three byte-wide registers through a simple I/O port with a combinational read:

- the external flag register;
- the external enable register;
- the timer enable register.

Edge detection on the pins, the timer itself and the core's context handling are outside the block.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_req` is low.
- R2: An event pulse sets its source's flag on the next clock edge, whether or not the source is enabled.
- R3: `irq_req` is high only when `gie` is 1 and at least one source has both its flag and its enable bit set.
- R4: The vector for each source is fixed:
  - external 0: 0x002
  - external 1: 0x004
  - external 2: 0x006
  - timer compare-match: 0x00E
  - timer overflow: 0x012
- R5: When several enabled flags are pending, the source with the lowest vector address is presented.
- R6: A one-cycle `irq_ack` while `irq_req` is high clears only the flag of the presented vector.
- R7: In the flag register, writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R8: If an event and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: The flag register is at I/O address 0x3A. The bit layout is:
  - bit 7: external source 1
  - bit 6: external source 0
  - bit 5: external source 2
  - bits 4..0: read as zero and ignore writes.
- R10: The timer enable register is at 0x39. Bit 7 enables overflow and bit 6 enables compare-match. Bits 5..0 are stored and read back but never enable a request.
- R11: The external enable register is at 0x3B. Bit 7 enables external 1, bit 6 enables external 0 and bit 5 enables external 2. Bits 4..0 read as zero.
- R12: A read from any other I/O address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gie | input | 1 | Global interrupt enable from the core |
| ext_evt | input | 3 | Event pulses from external sources 0..2 |
| tmr_cmpa_evt | input | 1 | Timer compare-match event pulse |
| tmr_ovf_evt | input | 1 | Timer overflow event pulse |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 12 | Vector address of the winning source |
| irq_ack | input | 1 | One-cycle acknowledge of the presented vector |

## Verification
The bench builds the block with its default addresses (0x3A, 0x39, 0x3B) and a two-stage reset synchroniser. With these values every register bit position and every vector value is directly observable. With all five sources enabled and pending at once, the full priority chain can be walked by successive acknowledges. Same-cycle collisions between an event and either kind of clear are driven explicitly, so the set-wins rule is exposed at the flag register.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC = 5;
  localparam int DW   = 8;
  localparam int VW   = 12;

  // Source indices in priority order (lowest index = lowest vector).
  localparam int S_EXT0 = 0;
  localparam int S_EXT1 = 1;
  localparam int S_EXT2 = 2;
  localparam int S_CMPA = 3;
  localparam int S_OVF  = 4;

  function automatic logic [VW-1:0] vec_of(input int idx);
    case (idx)
      S_EXT0:  vec_of = 12'h002;
      S_EXT1:  vec_of = 12'h004;
      S_EXT2:  vec_of = 12'h006;
      S_CMPA:  vec_of = 12'h00E;
      S_OVF:   vec_of = 12'h012;
      default: vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank
  import irqv_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    logic d;
    // A set in the same cycle as a clear wins so no event is lost.
    always_comb d = set_i[i] | (q & ~clr_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]  pending_i,
  output logic          req_o,
  output logic [N-1:0]  win_o,
  output logic [VW-1:0] vec_o
);
  logic found;

  always_comb begin
    win_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pending_i[i] && !found) begin
        win_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++)
      if (win_o[i]) vec_o = vec_of(i);
  end

  assign req_o = |pending_i;
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int                AW         = 6,
  parameter logic [AW-1:0]     FLAG_ADDR  = 6'h3A,
  parameter logic [AW-1:0]     TMASK_ADDR = 6'h39,
  parameter logic [AW-1:0]     EMASK_ADDR = 6'h3B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   io_addr,
  input  logic            io_wr,
  input  logic [DW-1:0]   io_wdata,
  input  logic [NSRC-1:0] flags_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] wr_clr_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] tmask_q, tmask_d;
  logic [2:0]    emask_q, emask_d;  // [0]=ext0, [1]=ext1, [2]=ext2
  logic          tm_we, em_we, fl_we;

  assign tm_we = io_wr && (io_addr == TMASK_ADDR);
  assign em_we = io_wr && (io_addr == EMASK_ADDR);
  assign fl_we = io_wr && (io_addr == FLAG_ADDR);

  always_comb begin
    tmask_d = tm_we ? io_wdata : tmask_q;
    emask_d = em_we ? {io_wdata[5], io_wdata[7], io_wdata[6]} : emask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmask_q <= '0;
      emask_q <= '0;
    end else begin
      tmask_q <= tmask_d;
      emask_q <= emask_d;
    end
  end

  // Write-one-to-clear on the external flags; timer flags clear only by ack.
  always_comb begin
    wr_clr_o         = '0;
    wr_clr_o[S_EXT0] = fl_we & io_wdata[6];
    wr_clr_o[S_EXT1] = fl_we & io_wdata[7];
    wr_clr_o[S_EXT2] = fl_we & io_wdata[5];
  end

  always_comb begin
    en_o         = '0;
    en_o[S_EXT0] = emask_q[0];
    en_o[S_EXT1] = emask_q[1];
    en_o[S_EXT2] = emask_q[2];
    en_o[S_CMPA] = tmask_q[6];
    en_o[S_OVF]  = tmask_q[7];
  end

  always_comb begin
    if (io_addr == FLAG_ADDR)
      rdata_o = {flags_i[S_EXT1], flags_i[S_EXT0], flags_i[S_EXT2], 5'b0};
    else if (io_addr == TMASK_ADDR)
      rdata_o = tmask_q;
    else if (io_addr == EMASK_ADDR)
      rdata_o = {emask_q[1], emask_q[0], emask_q[2], 5'b0};
    else
      rdata_o = '0;
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int            AW          = 6,
  parameter logic [AW-1:0] FLAG_ADDR   = 6'h3A,
  parameter logic [AW-1:0] TMASK_ADDR  = 6'h39,
  parameter logic [AW-1:0] EMASK_ADDR  = 6'h3B,
  parameter int            SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gie,
  input  logic [2:0]    ext_evt,
  input  logic          tmr_cmpa_evt,
  input  logic          tmr_ovf_evt,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          irq_req,
  output logic [11:0]   irq_vec,
  input  logic          irq_ack
);
  logic            srst_n;
  logic [NSRC-1:0] evts, flags, en, wr_clr, pending, win, clr;

  assign evts = {tmr_ovf_evt, tmr_cmpa_evt, ext_evt};

  irqv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(srst_n)
  );

  irqv_regs #(
    .AW(AW), .FLAG_ADDR(FLAG_ADDR), .TMASK_ADDR(TMASK_ADDR), .EMASK_ADDR(EMASK_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .flags_i(flags), .en_o(en), .wr_clr_o(wr_clr),
    .rdata_o(io_rdata)
  );

  assign pending = flags & en & {NSRC{gie}};

  irqv_arbiter #(.N(NSRC)) u_arb (
    .pending_i(pending), .req_o(irq_req), .win_o(win), .vec_o(irq_vec)
  );

  assign clr = wr_clr | (win & {NSRC{irq_ack}});

  irqv_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(srst_n), .set_i(evts), .clr_i(clr), .flags_o(flags)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
(
  input logic            clk,
  input logic            srst_n,
  input logic [NSRC-1:0] evts,
  input logic [NSRC-1:0] flags,
  input logic            gie,
  input logic            io_wr,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec
);
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (|evts) |=> ((flags & $past(evts)) == $past(evts)));

  p_gie_gates_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !gie |-> !irq_req);

  p_vec_legal_r4: assert property (@(posedge clk) disable iff (!srst_n)
    irq_req |-> (irq_vec == 12'h002 || irq_vec == 12'h004 || irq_vec == 12'h006 ||
                 irq_vec == 12'h00E || irq_vec == 12'h012));

  p_ack_one_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_ack && irq_req && !(|evts) && !io_wr)
      |=> ($countones(flags) + 1 == $countones($past(flags))));

  p_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!(|evts) && !io_wr && !irq_ack) |=> (flags == $past(flags)));
endmodule

bind irq_vector_unit irqv_checker u_chk (
  .clk(clk), .srst_n(srst_n), .evts(evts), .flags(flags), .gie(gie),
  .io_wr(io_wr), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gie;
  logic [2:0]  ext_evt;
  logic        tmr_cmpa_evt, tmr_ovf_evt;
  logic [5:0]  io_addr;
  logic        io_wr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        irq_req;
  logic [11:0] irq_vec;
  logic        irq_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [5:0] A_FLAG = 6'h3A, A_TM = 6'h39, A_EM = 6'h3B;

  always #2 clk = ~clk;  // 250 MHz

  irq_vector_unit dut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .ext_evt(ext_evt),
    .tmr_cmpa_evt(tmr_cmpa_evt), .tmr_ovf_evt(tmr_ovf_evt),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] e);  // {ovf, cmpa, ext2, ext1, ext0}
    @(negedge clk);
    {tmr_ovf_evt, tmr_cmpa_evt, ext_evt} = e;
    @(negedge clk);
    {tmr_ovf_evt, tmr_cmpa_evt, ext_evt} = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_FLAG, d); chk("R1 flag reg", d, 8'h00);
    rd(A_TM, d);   chk("R1 timer enable reg", d, 8'h00);
    rd(A_EM, d);   chk("R1 ext enable reg", d, 8'h00);
    chk("R1 req", irq_req, 1'b0);
  endtask

  task automatic t_set_unmasked();
    logic [7:0] d;
    gie = 1'b1;
    pulse(5'b11111);
    rd(A_FLAG, d); chk("R2 R9 flags set while disabled", d, 8'hE0);
    chk("R3 no req with enables off", irq_req, 1'b0);
  endtask

  task automatic t_write_clear();
    logic [7:0] d;
    wr(A_FLAG, 8'h40); rd(A_FLAG, d); chk("R7 clear ext0 only", d, 8'hA0);
    wr(A_FLAG, 8'h00); rd(A_FLAG, d); chk("R7 write zero no effect", d, 8'hA0);
    wr(A_FLAG, 8'h1F); rd(A_FLAG, d); chk("R9 reserved bits ignore writes", d, 8'hA0);
    wr(A_FLAG, 8'hA0); rd(A_FLAG, d); chk("R7 clear remaining", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_TM, 8'h3F); rd(A_TM, d); chk("R10 low bits stored", d, 8'h3F);
    chk("R10 low bits drive no req", irq_req, 1'b0);
    wr(A_EM, 8'hFF); rd(A_EM, d); chk("R11 ext enable readback", d, 8'hE0);
    rd(6'h10, d); chk("R12 other address", d, 8'h00);
    rd(6'h3C, d); chk("R12 neighbour address", d, 8'h00);
    wr(A_EM, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(A_TM, 8'hC0); wr(A_EM, 8'hE0);
    pulse(5'b11111);
    #1 chk("R5 R4 first vector ext0", irq_vec, 12'h002);
    chk("R3 req", irq_req, 1'b1);
    ack();
    rd(A_FLAG, d); chk("R6 ack clears only ext0", d, 8'hA0);
    chk("R4 ext1 vector", irq_vec, 12'h004);
    ack(); #1 chk("R4 ext2 vector", irq_vec, 12'h006);
    ack(); #1 chk("R4 compare vector", irq_vec, 12'h00E);
    ack(); #1 chk("R4 overflow vector", irq_vec, 12'h012);
    ack(); #1 chk("R6 all acked req low", irq_req, 1'b0);
  endtask

  task automatic t_gating();
    pulse(5'b01000);
    #1 chk("R3 req from compare flag", irq_req, 1'b1);
    gie = 1'b0;
    #1 chk("R3 gie low blocks", irq_req, 1'b0);
    gie = 1'b1;
    wr(A_TM, 8'h80); #1 chk("R10 overflow-only enable blocks compare", irq_req, 1'b0);
    wr(A_TM, 8'h40); #1 chk("R10 bit6 enables compare", irq_vec, 12'h00E);
    ack(); #1 chk("R6 compare cleared", irq_req, 1'b0);
  endtask

  task automatic t_race();
    logic [7:0] d;
    wr(A_EM, 8'h40);
    pulse(5'b00001);
    @(negedge clk);
    irq_ack = 1'b1; ext_evt = 3'b001;
    @(negedge clk);
    irq_ack = 1'b0; ext_evt = 3'b000;
    rd(A_FLAG, d); chk("R8 event beats ack", d, 8'h40);
    @(negedge clk);
    io_addr = A_FLAG; io_wdata = 8'h40; io_wr = 1'b1; ext_evt = 3'b001;
    @(negedge clk);
    io_wr = 1'b0; ext_evt = 3'b000;
    rd(A_FLAG, d); chk("R8 event beats write clear", d, 8'h40);
    wr(A_FLAG, 8'h40);
    rd(A_FLAG, d); chk("R7 final clear", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; gie = 1'b0; ext_evt = '0; tmr_cmpa_evt = 1'b0; tmr_ovf_evt = 1'b0;
    io_addr = '0; io_wr = 1'b0; io_wdata = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_unmasked();
    t_write_clear();
    t_regs();
    t_priority();
    t_gating();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule